// File: doc/BRIEF.md
# Parameterized Tag-Tracking Cache Probe

This block follows the tag state of a set-associative cache for a stream of byte addresses. It stores no data. Each cycle it can take one request. The request is decoded into a block offset, a set index and a tag. The block then looks for a matching valid way in the indexed set. It reports hit or miss in the next cycle and updates the set's contents and replacement order. Two running counters, one for accepted accesses and one for hits, give the hit rate. A test program can therefore infer block size, associativity, capacity and replacement policy by sending crafted address streams.

Block size, number of ways and total capacity are parameters. The number of sets follows from them. The replacement policy is chosen at run time by an input pin: least-recently-used or first-in-first-out. Both policies share one age ranking per set, so the pin may change between accesses. The cache starts empty and keeps its contents between access sequences. Only the clear input empties it, and a clear also zeroes both counters.

Top module: `tagcache_probe`

## Requirements
- R1: After reset or after a cycle with `clr` high, `acc_cnt` and `hit_cnt` are 0, `rsp_vld` is 0, and every set is empty, so the next access to any address misses.
- R2: A request is accepted in a cycle with `req_vld`=1 and `clr`=0. `rsp_vld` is 1 in the cycle after an accepted request and 0 in every other cycle. `rsp_hit` is valid only while `rsp_vld` is 1 and is 0 otherwise.
- R3: Address decode uses three fields, from low bits to high bits. Bits [log2(BLK_BYTES)-1:0] are the byte offset. The next log2(SETS) bits select the set, where SETS = CAP_BYTES/(BLK_BYTES*WAYS). All remaining upper bits form the tag. Two addresses that differ only in the offset hit the same block, and an address repeated on the next accepted request always hits.
- R4: On a miss, the lowest-numbered invalid way of the set is filled if one exists. Up to WAYS distinct tags therefore fit in one set with no eviction.
- R5: With `repl_fifo`=0 (LRU), both a hit and a fill make the accessed way the most recent. A miss in a full set evicts the least recently accessed tag.
- R6: With `repl_fifo`=1 (FIFO), a hit leaves the replacement order unchanged. A miss in a full set evicts the tag that was filled earliest.
- R7: Each accepted request increments `acc_cnt` by 1. Each accepted request that hits also increments `hit_cnt` by 1. `hit_cnt` never exceeds `acc_cnt`.
- R8: If `clr` and `req_vld` are high in the same cycle, the clear wins. The request is not counted and produces no response.
- R9: Without a clear, cache contents and counters persist across any number of idle cycles and across successive access sequences.
- R10: A cycle with `req_vld`=0 and `clr`=0 leaves counters and contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of contents and counters |
| req_vld | input | 1 | Access request strobe |
| req_addr | input | ADDR_W | Byte address of the access |
| repl_fifo | input | 1 | Replacement select: 0 = LRU, 1 = FIFO |
| rsp_vld | output | 1 | Result valid, one cycle after an accepted request |
| rsp_hit | output | 1 | 1 = the access hit |
| acc_cnt | output | CNT_W | Accepted access count |
| hit_cnt | output | CNT_W | Hit count |

## Verification
The hardest case to reach from the ports is a victim choice in a full set whose earlier hits would change the LRU result but must not change the FIFO result. This case needs a set filled to capacity, an access pattern that makes the two policies disagree, and then a probe of the tag that one of them should have evicted. Directed streams build this case in one set under each policy. A long random stream then confines addresses to four sets and twelve tags and toggles the policy mid-run, so evictions become frequent. A behavioural recency-queue model is compared with every cycle.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  // index width that never collapses to zero bits
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tcp_addr_split.sv
module tcp_addr_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 5,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned TAG_W  = 22
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  logic unused_offset;

  assign idx           = addr[OFF_W +: IDX_W];
  assign tag           = addr[ADDR_W-1 -: TAG_W];
  assign unused_offset = ^addr[OFF_W-1:0];
endmodule

// File: rtl/tcp_way_match.sv
module tcp_way_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 22,
  parameter int unsigned WAY_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WAYS-1:0][TAG_W-1:0]  row_tag,
  input  logic [WAYS-1:0]             row_vld,
  input  logic [TAG_W-1:0]            tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic                        free_any,
  output logic [WAY_W-1:0]            free_way
);
  logic [WAYS-1:0] hit_vec;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign hit_vec[g] = row_vld[g] && (row_tag[g] == tag);
    end
  endgenerate

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way  = WAY_W'(w);
      if (!row_vld[w]) free_way = WAY_W'(w);
    end
  end

  assign hit      = |hit_vec;
  assign free_any = ~&row_vld;

  // R4
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/tcp_repl_rank.sv
module tcp_repl_rank #(
  parameter int unsigned WAYS   = 4,
  parameter int unsigned RANK_W = 2,
  parameter int unsigned WAY_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        active,
  input  logic [WAYS-1:0][RANK_W-1:0] row_rank,
  input  logic                        hit,
  input  logic [WAY_W-1:0]            hit_way,
  input  logic                        free_any,
  input  logic [WAY_W-1:0]            free_way,
  input  logic                        fifo,
  output logic                        touch,
  output logic [WAY_W-1:0]            fill_way,
  output logic [WAYS-1:0][RANK_W-1:0] nxt_rank
);
  logic [WAYS-1:0]   vic_vec;
  logic [WAY_W-1:0]  vic_way;
  logic [WAY_W-1:0]  tw;
  logic [RANK_W-1:0] tw_rank;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_vic
      assign vic_vec[g] = (row_rank[g] == RANK_W'(WAYS - 1));
    end
  endgenerate

  always_comb begin
    vic_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (vic_vec[w]) vic_way = WAY_W'(w);
  end

  assign fill_way = free_any ? free_way : vic_way;
  assign touch    = !hit || !fifo;
  assign tw       = hit ? hit_way : fill_way;
  assign tw_rank  = row_rank[tw];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == tw)            nxt_rank[w] = '0;
      else if (row_rank[w] < tw_rank) nxt_rank[w] = row_rank[w] + RANK_W'(1);
      else                            nxt_rank[w] = row_rank[w];
    end
  end

  // R5
  unique_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> $onehot(vic_vec));
endmodule

// File: rtl/tcp_stats.sv
module tcp_stats #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             acc_en,
  input  logic             hit_en,
  output logic [CNT_W-1:0] acc_cnt,
  output logic [CNT_W-1:0] hit_cnt
);
  logic [CNT_W-1:0] acc_d, hit_d;

  always_comb begin
    acc_d = acc_cnt;
    hit_d = hit_cnt;
    if (clr) begin
      acc_d = '0;
      hit_d = '0;
    end else if (acc_en) begin
      acc_d = acc_cnt + CNT_W'(1);
      if (hit_en) hit_d = hit_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      hit_cnt <= '0;
    end else begin
      acc_cnt <= acc_d;
      hit_cnt <= hit_d;
    end
  end

  // R7
  hits_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cnt <= acc_cnt);
  // R7
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !clr) |=> acc_cnt == $past(acc_cnt) + CNT_W'(1));
  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_cnt == '0 && hit_cnt == '0));
endmodule

// File: rtl/tagcache_probe.sv
module tagcache_probe #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BLK_BYTES = 32,
  parameter int unsigned WAYS      = 4,
  parameter int unsigned CAP_BYTES = 4096,
  parameter int unsigned CNT_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              repl_fifo,
  output logic              rsp_vld,
  output logic              rsp_hit,
  output logic [CNT_W-1:0]  acc_cnt,
  output logic [CNT_W-1:0]  hit_cnt
);
  localparam int unsigned SETS   = CAP_BYTES / (BLK_BYTES * WAYS);
  localparam int unsigned OFF_W  = $clog2(BLK_BYTES);
  localparam int unsigned IDX_W  = tcp_pkg::idx_w(SETS);
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int unsigned WAY_W  = tcp_pkg::idx_w(WAYS);
  localparam int unsigned RANK_W = WAY_W;

  logic [WAYS-1:0][TAG_W-1:0]  tag_q  [SETS];
  logic [WAYS-1:0]             vld_q  [SETS];
  logic [WAYS-1:0][RANK_W-1:0] rank_q [SETS];

  logic [IDX_W-1:0]            idx;
  logic [TAG_W-1:0]            tag;
  logic [WAYS-1:0][TAG_W-1:0]  row_tag, tag_d;
  logic [WAYS-1:0]             row_vld, vld_d;
  logic [WAYS-1:0][RANK_W-1:0] row_rank, rank_d;
  logic                        hit, free_any, touch, req_go;
  logic [WAY_W-1:0]            hit_way, free_way, fill_way;

  assign req_go   = req_vld && !clr;
  assign row_tag  = tag_q[idx];
  assign row_vld  = vld_q[idx];
  assign row_rank = rank_q[idx];

  tcp_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split (
    .addr(req_addr), .idx(idx), .tag(tag));

  tcp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .clk(clk), .rst_n(rst_n), .row_tag(row_tag), .row_vld(row_vld), .tag(tag),
    .hit(hit), .hit_way(hit_way), .free_any(free_any), .free_way(free_way));

  tcp_repl_rank #(.WAYS(WAYS), .RANK_W(RANK_W), .WAY_W(WAY_W)) u_repl (
    .clk(clk), .rst_n(rst_n), .active(req_go), .row_rank(row_rank), .hit(hit),
    .hit_way(hit_way), .free_any(free_any), .free_way(free_way), .fifo(repl_fifo),
    .touch(touch), .fill_way(fill_way), .nxt_rank(rank_d));

  tcp_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_en(req_go), .hit_en(hit),
    .acc_cnt(acc_cnt), .hit_cnt(hit_cnt));

  // next row contents on a fill
  always_comb begin
    tag_d = row_tag;
    vld_d = row_vld;
    tag_d[fill_way] = tag;
    vld_d[fill_way] = 1'b1;
  end

  // tag storage: no reset, written only on a fill
  always_ff @(posedge clk) begin
    if (req_go && !hit) tag_q[idx] <= tag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld <= 1'b0;
      rsp_hit <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) rank_q[s][w] <= RANK_W'(w);
      end
    end else if (clr) begin
      rsp_vld <= 1'b0;
      rsp_hit <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) rank_q[s][w] <= RANK_W'(w);
      end
    end else begin
      rsp_vld <= req_vld;
      rsp_hit <= req_vld && hit;
      if (req_vld && !hit) vld_q[idx]  <= vld_d;
      if (req_vld && touch) rank_q[idx] <= rank_d;
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_go |=> rsp_vld);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_go |=> !rsp_vld);
  // R2
  hit_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_vld);
  // R3
  repeat_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_go && $past(req_vld && !clr) && req_addr == $past(req_addr)) |=> rsp_hit);
endmodule

// File: tb/tb_tagcache_probe.sv
module tb_tagcache_probe;
  localparam int BLK = 32, NWAY = 4, CAP = 4096;
  localparam int NSET = CAP / (BLK * NWAY);
  localparam int STRIDE = BLK * NSET;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, req_vld = 1'b0, repl_fifo = 1'b0;
  logic [31:0] req_addr = '0;
  logic rsp_vld, rsp_hit;
  logic [31:0] acc_cnt, hit_cnt;

  int tests = 0, fails = 0, cyc = 0;
  int exp_acc = 0, exp_hits = 0;
  bit exp_vld = 0, exp_hit = 0, done = 0;
  int mq [NSET][$];

  always #4 clk = ~clk;

  tagcache_probe dut (.clk(clk), .rst_n(rst_n), .clr(clr), .req_vld(req_vld),
    .req_addr(req_addr), .repl_fifo(repl_fifo), .rsp_vld(rsp_vld), .rsp_hit(rsp_hit),
    .acc_cnt(acc_cnt), .hit_cnt(hit_cnt));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic compare(input string rq);
    tests++;
    if (rsp_vld !== exp_vld || rsp_hit !== exp_hit ||
        acc_cnt !== 32'(exp_acc) || hit_cnt !== 32'(exp_hits)) begin
      fails++;
      $display("FAIL %s: vld/hit/acc/hits got %0b/%0b/%0d/%0d expected %0b/%0b/%0d/%0d",
               rq, rsp_vld, rsp_hit, acc_cnt, hit_cnt, exp_vld, exp_hit, exp_acc, exp_hits);
    end
  endtask

  // recency queue per set: front = most recent / newest
  task automatic step(input bit v, input int a, input bit f, input bit c, input string rq);
    int s, t, pos;
    @(negedge clk);
    req_vld = v; req_addr = a; repl_fifo = f; clr = c;
    exp_vld = 0; exp_hit = 0;
    if (c) begin
      for (int i = 0; i < NSET; i++) mq[i].delete();
      exp_acc = 0; exp_hits = 0;
    end else if (v) begin
      s = (a / BLK) % NSET;
      t = a / STRIDE;
      pos = -1;
      for (int i = 0; i < mq[s].size(); i++) if (mq[s][i] == t) pos = i;
      exp_vld = 1;
      exp_acc++;
      if (pos >= 0) begin
        exp_hit = 1;
        exp_hits++;
        if (!f) begin
          mq[s].delete(pos);
          mq[s].push_front(t);
        end
      end else begin
        if (mq[s].size() == NWAY) void'(mq[s].pop_back());
        mq[s].push_front(t);
      end
    end
    @(posedge clk);
    #1;
    compare(rq);
  endtask

  task automatic expect_hit(input bit h, input string rq);
    tests++;
    if (rsp_hit !== h) begin
      fails++;
      $display("FAIL %s: directed hit got %0b expected %0b", rq, rsp_hit, h);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare("R1 reset state");

    // R3: same block, different offsets; neighbour block misses
    step(1, 32'h40, 0, 0, "R3"); expect_hit(0, "R3 first touch");
    step(1, 32'h5F, 0, 0, "R3"); expect_hit(1, "R3 same block");
    step(1, 32'h60, 0, 0, "R3"); expect_hit(0, "R3 next block");
    step(1, 32'h60, 0, 0, "R3");

    // R4: fill set 0 with NWAY tags, then all hit
    for (int k = 0; k < NWAY; k++) step(1, k * STRIDE, 0, 0, "R4 fill");
    for (int k = 0; k < NWAY; k++) begin
      step(1, k * STRIDE + 4, 0, 0, "R4 retain");
      expect_hit(1, "R4 retain");
    end

    // R5 LRU: touch tag 0, miss evicts tag 1 (least recent), tag 0 survives
    step(1, 0, 0, 0, "R5");
    step(1, 4 * STRIDE, 0, 0, "R5 evict");
    step(1, 0, 0, 0, "R5"); expect_hit(1, "R5 promoted tag kept");
    step(1, 1 * STRIDE, 0, 0, "R5"); expect_hit(0, "R5 LRU victim gone");

    // R6 FIFO on set 5: hits do not save the oldest fill
    for (int k = 0; k < NWAY; k++) step(1, k * STRIDE + 5 * BLK, 1, 0, "R6 fill");
    step(1, 5 * BLK, 1, 0, "R6"); expect_hit(1, "R6 oldest present");
    step(1, 9 * STRIDE + 5 * BLK, 1, 0, "R6 evict");
    step(1, 1 * STRIDE + 5 * BLK, 1, 0, "R6"); expect_hit(1, "R6 second fill kept");
    step(1, 5 * BLK, 1, 0, "R6"); expect_hit(0, "R6 oldest evicted despite hit");

    // R10: idle cycles
    for (int k = 0; k < 6; k++) step(0, 32'hDEAD_BEE0, k[0], 0, "R10 idle");

    // R9: contents persist across sequences
    step(1, 32'h44, 0, 0, "R9"); expect_hit(1, "R9 earlier block still held");

    // R8: clear wins over a request
    step(1, 32'h44, 0, 1, "R8 clear with request");
    step(0, 0, 0, 0, "R8 no response");

    // R1: after clear everything misses
    step(1, 32'h44, 0, 0, "R1"); expect_hit(0, "R1 empty after clear");

    // R7: random stream over 4 sets and 12 tags, policy toggled
    for (int n = 0; n < 3000; n++) begin
      int a;
      a = $urandom_range(0, 11) * STRIDE + $urandom_range(0, 3) * BLK + $urandom_range(0, BLK - 1);
      step($urandom_range(0, 7) != 0, a, (n / 200) % 2 == 1, $urandom_range(0, 499) == 0,
           "R7 stream");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule